// File: doc/BRIEF.md
# Gated Dual-Counter Frequency Meter

This block measures how fast an oscillator runs by comparing it with a known reference. Two 16-bit counters work together. The gate counter counts a fixed number of ticks from one source, and that count sets the length of the measuring window. The measurement counter counts ticks from the other source while the window is open. Both sources arrive as single-cycle tick strobes in the system clock domain. The measured source can optionally pass through a divide-by-256 prescaler first, which is the path used for a radio-frequency oscillator.

Software drives the block through one 8-bit control byte and reads back through a small address decoder. The control byte can clear counter 1, preset both counters to all ones, start and stop the measurement, choose which counter is read back, swap the roles of the two sources, and set the window length. The window length is one of eight odd powers of two, from 2 to 32768. When the window closes, both counters freeze and the block raises a one-cycle done pulse for the interrupt logic. A sticky overflow flag reports that counter 1 wrapped.

Top module: `fmm_freq_meter`

## Requirements
- R1: After reset, both counters are zero, `ovf_flag` and `done_pulse` are low, and the control byte is 08h: straight mapping, measurement disabled, counter 1 selected.
- R2: A write to the control byte takes effect from the next cycle. Its bits are: bit 7 = clear counter 1, bits 6:4 = window code, bit 3 = straight mapping (active-low swap), bit 2 = enable, bit 1 = read select (0 selects counter 1, 1 selects counter 2), bit 0 = preset.
- R3: The gate counter stops on the tick that brings its value to S-1, where S = 2^(2·code+1). Starting from the all-ones preset, this takes exactly S gate ticks.
- R4: While the clear bit is set, counter 1 and the prescaler stay at zero and `ovf_flag` is low, whatever ticks arrive.
- R5: While the preset bit is set, both counters read FFFFh and no counting takes place.
- R6: With bit 3 set, the measured source drives counter 1 and the reference drives the gate counter (counter 2). With bit 3 clear, the two are exchanged.
- R7: While the enable bit is 0, neither counter changes and no done pulse is raised.
- R8: Read address 0Ah returns the low byte of the selected counter and 0Bh returns its high byte. Every other address returns 00h.
- R9: `ovf_flag` goes high when counter 1 wraps from FFFFh to 0000h. It then stays high until the clear bit is set.
- R10: With `meas_prescale` high, the measured source advances its counter once per 256 measured ticks.
- R11: `done_pulse` is high for exactly one cycle, in the cycle after the terminating gate tick. Counter 1 still counts a tick that arrives in the same cycle as the terminating gate tick. After that, both counters hold their values.
- R12: Any write to the control byte releases the freeze. With the enable bit set, counting then resumes from the held values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Write strobe for the control byte |
| ctrl_wdata | input | 8 | Control byte value |
| rd_addr | input | 4 | Read address |
| meas_tick | input | 1 | One-cycle strobe per edge of the measured oscillator |
| meas_prescale | input | 1 | Route the measured source through the divide-by-256 prescaler |
| ref_tick | input | 1 | One-cycle strobe per edge of the reference |
| rd_data | output | 8 | Byte read from the selected counter |
| ovf_flag | output | 1 | Sticky wrap flag of counter 1 |
| done_pulse | output | 1 | One-cycle measurement-done event |

## Verification
Two events can fall in the same cycle: the terminating gate tick and a tick on the counted source. The bench provokes this by ticking the measured source every cycle while the reference ticks on alternate cycles, so the last reference tick always lands together with a measured tick. The result is judged by reading counter 1 back: it must include that final tick (2S-1 for window size S). The done pulse must appear exactly at the matching cycle index. The same coincidence is repeated with the sources swapped, and once more with both sources ticking every cycle.

// File: rtl/fmm_pkg.sv
// Shared types and helpers of the frequency meter.
// Assumes a 3-bit window code and a counter width of at least 16 bits.
package fmm_pkg;

    localparam int CNT_W = 16;

    // Control byte layout; the bit order is decoded by software.
    typedef struct packed {
        logic       clr1;      // hold counter 1 at zero
        logic [2:0] win;       // window code
        logic       straight;  // 1: measured->c1, reference->c2
        logic       enable;    // run the measurement
        logic       sel2;      // read back counter 2
        logic       preset;    // hold both counters at all ones
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{clr1: 1'b0, win: 3'd0, straight: 1'b1,
                                     enable: 1'b0, sel2: 1'b0, preset: 1'b0};

    // Window size: 2^(2*code+1) gate ticks.
    function automatic logic [CNT_W-1:0] win_size(input logic [2:0] code);
        return CNT_W'(1) << {code, 1'b1};
    endfunction

endpackage

// File: rtl/fmm_prescaler.sv
// Optional power-of-two divider for the measured tick stream.
// Emits one tick per 2^DIV_LOG2 input ticks, or passes ticks through when bypassed.
// Assumes tick_in is a one-cycle strobe in the clk domain.
module fmm_prescaler #(
    parameter int DIV_LOG2 = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic divide,
    input  logic tick_in,
    output logic tick_out
);
    logic [DIV_LOG2-1:0] phase_q;

    // Phase counter: reset on hold, advance on each divided input tick.
    always_ff @(posedge clk) begin
        if (!rst_n || hold)
            phase_q <= '0;
        else if (tick_in && divide)
            phase_q <= phase_q + 1'b1;
    end

    // Output tick: straight through, or at the last phase of the divider.
    always_comb begin
        if (divide)
            tick_out = tick_in && (&phase_q);
        else
            tick_out = tick_in;
    end
endmodule

// File: rtl/fmm_counter.sv
// Up-counter with hold-at-zero and hold-at-all-ones controls.
// Zero hold wins over ones hold; wrap flags an increment from all ones.
module fmm_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         zero_hold,
    input  logic         ones_hold,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic         wrap
);
    // Count register with the two hold modes.
    always_ff @(posedge clk) begin
        if (!rst_n || zero_hold)
            value <= '0;
        else if (ones_hold)
            value <= '1;
        else if (inc)
            value <= value + 1'b1;
    end

    // Wrap event: increment accepted while at all ones.
    always_comb wrap = inc && !zero_hold && !ones_hold && (&value);
endmodule

// File: rtl/fmm_freq_meter.sv
// Gated dual-counter frequency meter.
// Counter 2 counts gate ticks until the window size is reached, then both
// counters freeze and a one-cycle done pulse is raised. Counter 1 counts the
// other source while the window is open. All ticks are clk-domain strobes.
module fmm_freq_meter #(
    parameter int          CNT_W    = fmm_pkg::CNT_W,
    parameter int          PRE_LOG2 = 8,
    parameter logic [3:0]  ADDR_LO  = 4'hA,
    parameter logic [3:0]  ADDR_HI  = 4'hB
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [7:0] ctrl_wdata,
    input  logic [3:0] rd_addr,
    input  logic       meas_tick,
    input  logic       meas_prescale,
    input  logic       ref_tick,
    output logic [7:0] rd_data,
    output logic       ovf_flag,
    output logic       done_pulse
);
    import fmm_pkg::*;

    localparam int HALF = CNT_W / 2;

    ctrl_t              ctrl_q;
    logic               frozen_q;
    logic               run;
    logic               meas_src;
    logic               c1_tick, c2_tick;
    logic               c1_inc, c2_inc;
    logic               c1_wrap, c2_wrap;
    logic [CNT_W-1:0]   c1_val, c2_val;
    logic [CNT_W-1:0]   term_pre;
    logic               term_evt;
    logic [CNT_W-1:0]   rd_word;

    // Control byte register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= CTRL_RESET;
        else if (ctrl_wr)
            ctrl_q <= ctrl_t'(ctrl_wdata);
    end

    // Counting is allowed while enabled, not frozen and not preset.
    always_comb run = ctrl_q.enable && !frozen_q && !ctrl_q.preset;

    fmm_prescaler #(.DIV_LOG2(PRE_LOG2)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (ctrl_q.preset || ctrl_q.clr1),
        .divide   (meas_prescale),
        .tick_in  (meas_tick && run),
        .tick_out (meas_src)
    );

    // Source routing: straight or swapped.
    always_comb begin
        if (ctrl_q.straight) begin
            c1_tick = meas_src;
            c2_tick = ref_tick;
        end else begin
            c1_tick = ref_tick;
            c2_tick = meas_src;
        end
        c1_inc = run && c1_tick;
        c2_inc = run && c2_tick;
    end

    fmm_counter #(.W(CNT_W)) u_cnt1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .zero_hold (ctrl_q.clr1),
        .ones_hold (ctrl_q.preset),
        .inc       (c1_inc),
        .value     (c1_val),
        .wrap      (c1_wrap)
    );

    fmm_counter #(.W(CNT_W)) u_cnt2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .zero_hold (1'b0),
        .ones_hold (ctrl_q.preset),
        .inc       (c2_inc),
        .value     (c2_val),
        .wrap      (c2_wrap)
    );

    // Terminal condition: the gate tick that moves counter 2 to size-1.
    always_comb begin
        term_pre = win_size(ctrl_q.win) - CNT_W'(2);
        term_evt = c2_inc && (c2_val == term_pre);
    end

    // Freeze state: set at window end, released by preset or any control write.
    always_ff @(posedge clk) begin
        if (!rst_n || ctrl_q.preset || ctrl_wr)
            frozen_q <= 1'b0;
        else if (term_evt)
            frozen_q <= 1'b1;
    end

    // Done pulse: one cycle, registered from the terminal condition.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_pulse <= 1'b0;
        else
            done_pulse <= term_evt;
    end

    // Sticky wrap flag of counter 1, cleared while clear is held.
    always_ff @(posedge clk) begin
        if (!rst_n || ctrl_q.clr1)
            ovf_flag <= 1'b0;
        else if (c1_wrap)
            ovf_flag <= 1'b1;
    end

    // Readout mux: selected counter split into two bytes.
    always_comb begin
        rd_word = ctrl_q.sel2 ? c2_val : c1_val;
        case (rd_addr)
            ADDR_LO: rd_data = rd_word[7:0];
            ADDR_HI: rd_data = rd_word[HALF+7:HALF];
            default: rd_data = 8'h00;
        endcase
    end

    // The gate counter's wrap has no consumer; fold it into a named sink.
    logic unused_c2_wrap;
    always_comb unused_c2_wrap = c2_wrap;
endmodule

// File: rtl/fmm_freq_meter_chk.sv
// Property checker for the frequency meter, bound to every instance.
module fmm_freq_meter_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_wr,
    input logic             clr1,
    input logic             preset,
    input logic [2:0]       win,
    input logic             frozen,
    input logic [CNT_W-1:0] c1,
    input logic [CNT_W-1:0] c2,
    input logic             ovf,
    input logic             done
);
    import fmm_pkg::*;

    // R4: a clear held over two cycles leaves counter 1 and the flag at zero.
    assert_clear_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr1 && $past(clr1)) |-> (c1 == '0 && !ovf));

    // R5: a preset held over two cycles keeps counter 2 at all ones.
    assert_preset_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (preset && $past(preset)) |-> (c2 == '1));

    // R11: the done pulse never lasts two cycles.
    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: at the done pulse, counter 2 sits one below the window size.
    assert_done_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (c2 == win_size(win) - CNT_W'(1)));

    // R11: a frozen meter holds both counters until a control write.
    assert_frozen_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !ctrl_wr && !clr1 && !preset) |=> ($stable(c1) && $stable(c2)));

    // R9: the flag only rises on a wrap of counter 1.
    assert_ovf_on_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> (c1 == '0 && $past(c1) == '1));
endmodule

bind fmm_freq_meter fmm_freq_meter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_wr (ctrl_wr),
    .clr1    (ctrl_q.clr1),
    .preset  (ctrl_q.preset),
    .win     (ctrl_q.win),
    .frozen  (frozen_q),
    .c1      (c1_val),
    .c2      (c2_val),
    .ovf     (ovf_flag),
    .done    (done_pulse)
);

// File: tb/fmm_freq_meter_tb_top.sv
// Directed bench for the frequency meter; one task per scenario.
module fmm_freq_meter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [7:0] ctrl_wdata = 8'h00;
    logic [3:0] rd_addr = 4'h0;
    logic       meas_tick = 1'b0;
    logic       meas_prescale = 1'b0;
    logic       ref_tick = 1'b0;
    logic [7:0] rd_data;
    logic       ovf_flag;
    logic       done_pulse;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    fmm_freq_meter dut_i (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .rd_addr(rd_addr), .meas_tick(meas_tick), .meas_prescale(meas_prescale),
        .ref_tick(ref_tick), .rd_data(rd_data), .ovf_flag(ovf_flag),
        .done_pulse(done_pulse)
    );

    // Control byte: {clr1, win[2:0], straight, enable, sel2, preset}.
    function automatic logic [7:0] cb(bit clr, bit [2:0] w, bit st, bit en, bit s2, bit pr);
        return {clr, w, st, en, s2, pr};
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        ctrl_wr = 1'b1; ctrl_wdata = v;
        @(negedge clk);
        ctrl_wr = 1'b0;
        @(negedge clk);
    endtask

    // Select a counter for readout (measurement disabled) and read both bytes.
    task automatic rd16(input bit s2, output int v);
        logic [7:0] lo;
        wr(cb(0, 3'd0, 1, 0, s2, 0));
        rd_addr = 4'hA; #1 lo = rd_data;
        rd_addr = 4'hB; #1 v = {rd_data, lo};
        rd_addr = 4'h0;
    endtask

    // Preset, then clear counter 1; leaves c1=0, c2=FFFF, enabled if en.
    task automatic arm(input bit [2:0] w, input bit st, input bit en);
        wr(cb(0, w, st, 0, 0, 1));
        wr(cb(1, w, st, 0, 0, 0));
        wr(cb(0, w, st, en, 0, 0));
    endtask

    // Drive n cycles; a source ticks when (i-1) % period == 0 (period 0 = never).
    task automatic run_ticks(input int n, input int mp, input int rp,
                             output int pulses, output int first);
        pulses = 0; first = -1;
        for (int i = 1; i <= n; i++) begin
            meas_tick = (mp > 0) && ((i - 1) % mp == 0);
            ref_tick  = (rp > 0) && ((i - 1) % rp == 0);
            @(negedge clk);
            if (done_pulse) begin
                pulses++;
                if (first < 0) first = i;
            end
        end
        meas_tick = 1'b0; ref_tick = 1'b0;
    endtask

    task automatic t_reset;
        rd_addr = 4'hA; #1 chk("R1 low byte after reset", rd_data, 0);
        rd_addr = 4'hB; #1 chk("R1 high byte after reset", rd_data, 0);
        rd_addr = 4'h0;
        chk("R1 ovf after reset", ovf_flag, 0);
        chk("R1 done after reset", done_pulse, 0);
    endtask

    task automatic t_short_window;
        int p, f, v;
        arm(3'd0, 1, 1);
        run_ticks(6, 1, 1, p, f);
        chk("R3 R11 one pulse, window 2", p, 1);
        chk("R11 pulse cycle, window 2", f, 2);
        rd16(0, v); chk("R11 c1 frozen after window 2", v, 2);
        rd16(1, v); chk("R3 c2 at size-1", v, 1);
        // R12: a fresh enable write resumes counting from held values.
        wr(cb(0, 3'd0, 1, 1, 0, 0));
        run_ticks(3, 0, 1, p, f);
        chk("R12 no pulse after release", p, 0);
        rd16(1, v); chk("R12 c2 resumed", v, 4);
    endtask

    task automatic t_coincide;
        int p, f, v;
        arm(3'd1, 1, 1);
        run_ticks(20, 1, 2, p, f);
        chk("R3 pulse count, window 8", p, 1);
        chk("R11 pulse on 8th gate tick", f, 15);
        rd16(0, v); chk("R11 coinciding tick counted", v, 15);
        rd16(1, v); chk("R2 R3 c2 readout window 8", v, 7);
    endtask

    task automatic t_swap;
        int p, f, v;
        arm(3'd0, 0, 1);
        run_ticks(8, 2, 1, p, f);
        chk("R6 swapped pulse cycle", f, 3);
        rd16(0, v); chk("R6 c1 counts reference", v, 3);
        rd16(1, v); chk("R6 c2 counts measured", v, 1);
    endtask

    task automatic t_disabled;
        int p, f, v;
        arm(3'd0, 1, 0);
        run_ticks(5, 1, 1, p, f);
        chk("R7 no pulse while disabled", p, 0);
        rd16(0, v); chk("R7 c1 unchanged", v, 0);
        rd16(1, v); chk("R7 c2 unchanged", v, 16'hFFFF);
    endtask

    task automatic t_overflow_clear;
        int p, f, v;
        wr(cb(0, 3'd7, 1, 0, 0, 1));
        wr(cb(0, 3'd7, 1, 1, 0, 0));
        run_ticks(1, 1, 0, p, f);
        chk("R9 ovf on wrap", ovf_flag, 1);
        run_ticks(4, 1, 0, p, f);
        chk("R9 ovf sticky", ovf_flag, 1);
        rd16(0, v); chk("R9 c1 after wrap", v, 4);
        wr(cb(1, 3'd7, 1, 1, 0, 0));
        run_ticks(3, 1, 0, p, f);
        chk("R4 ovf cleared", ovf_flag, 0);
        rd16(0, v); chk("R4 c1 held at zero", v, 0);
    endtask

    task automatic t_preset;
        int p, f, v;
        wr(cb(0, 3'd0, 1, 1, 0, 1));
        run_ticks(4, 1, 1, p, f);
        chk("R5 no pulse under preset", p, 0);
        rd16(0, v); chk("R5 c1 all ones", v, 16'hFFFF);
        rd16(1, v); chk("R5 c2 all ones", v, 16'hFFFF);
    endtask

    task automatic t_prescale;
        int p, f, v;
        meas_prescale = 1'b1;
        arm(3'd4, 1, 1);
        run_ticks(520, 1, 1, p, f);
        chk("R10 pulse at 512", f, 512);
        rd16(0, v); chk("R10 prescaled c1", v, 2);
        wr(cb(0, 3'd0, 1, 0, 1, 0));
        rd_addr = 4'hB; #1 chk("R8 high byte", rd_data, 8'h01);
        rd_addr = 4'hA; #1 chk("R8 low byte", rd_data, 8'hFF);
        rd_addr = 4'h3; #1 chk("R8 other address", rd_data, 8'h00);
        rd_addr = 4'h0;
        meas_prescale = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short_window();
        t_coincide();
        t_swap();
        t_disabled();
        t_overflow_clear();
        t_preset();
        t_prescale();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule